// File: doc/BRIEF.md
# SDRAM Read/Write Data Path

This block is the data half of a single-data-rate synchronous DRAM controller. A command sequencer tells it, one cycle ahead of the command pins, that a write or read burst is starting. The block then produces the pad-side data signals for that burst. For a write it drives the data bus enable, the write byte and the data mask pin on every beat. For a read it releases the bus, follows the returning beats through a short delay line that the programmed CAS latency taps, and captures each beat. It raises a read-valid strobe for every beat that was not masked.

Burst length comes from a 2-bit code, and the CAS latency from a one-bit select. All pad outputs are registered, so they line up with the command pins, which the sequencer registers the same way. A new command that arrives before the current burst has finished cuts that burst short and starts the new one. The mask pin serves both directions. A write mask takes effect on the beat it is driven with. A read mask takes effect on the data the memory returns two cycles after it samples the mask.

Top module: `sdr_dpath`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `dq_oe`, `dqm`, `rd_valid`, `dq_out` and `rd_data` are all zero.
- R2: `bl_code` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. A command sampled at edge n produces beats at the input-side edges n to n+BL-1.
- R3: For a write command sampled at edge n, `dq_oe` is high in the cycles after the edges n to n+BL-1 and in no other cycle. In each of those cycles `dq_out` carries the `wr_data` sampled at that edge.
- R4: The write mask has zero latency. During a write beat, `dqm` carries the `wr_mask` sampled together with that beat's data, in the same cycle as `dq_out`.
- R5: `cas_lat3`=0 selects CAS latency 2 and `cas_lat3`=1 selects latency 3. Read beat k of a command sampled at edge n is taken from `dq_in` at edge n+1+CL+k. `rd_valid` is high for the cycle after that edge, with the beat on `rd_data`.
- R6: The read mask has a latency of 2. Outside write beats, `dqm` follows the `rd_mask` sampled one edge earlier. An `rd_mask` sampled at edge m suppresses the beat captured at edge m+3: `rd_valid` stays low and `rd_data` keeps its previous value.
- R7: `dq_oe` is low in the cycle after a read command is sampled. It stays low while that burst's beats return.
- R8: A read or write command sampled while a burst is still running ends that burst at once. The new burst then runs its full length.
- R9: When `wr_cmd` and `rd_cmd` are sampled high together, the write is performed and the read is dropped.
- R10: When no write beat is in progress, `dq_out` holds the last write byte. The mask pin drives no write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cas_lat3 | input | 1 | CAS latency select: 0 = 2 cycles, 1 = 3 cycles |
| bl_code | input | 2 | Burst length code, BL = 2^code |
| wr_cmd | input | 1 | Write burst starts on this edge |
| rd_cmd | input | 1 | Read burst starts on this edge |
| wr_data | input | 8 | Write byte for the current beat |
| wr_mask | input | 1 | Mask request for the current write beat |
| rd_mask | input | 1 | Read mask request, effective two pad cycles later |
| dq_in | input | 8 | Data returned from the memory bus |
| dq_oe | output | 1 | Bus drive enable |
| dq_out | output | 8 | Write data to the bus |
| dqm | output | 1 | Data mask pin |
| rd_data | output | 8 | Captured read beat |
| rd_valid | output | 1 | `rd_data` holds a new, unmasked beat |

## Verification
The hardest case to reach is a read burst that is cut short by a second read while a mask request is landing on a beat. Here the truncated burst, the new burst and the mask each arrive at the capture register through a different delay. The stimulus sets this up under both CAS latencies. It issues the second command a few cycles into an 8-beat burst and places mask requests on input cycles chosen to hit beats of both bursts. It then predicts every capture cycle from the input-cycle arithmetic of R5 and R6. Data returned on `dq_in` changes every cycle, so a capture that is off by one cycle reads a wrong byte.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } burst_dir_e;

  // burst length in beats from its 2^code encoding
  function automatic int unsigned beats_of(input int unsigned code);
    return 32'd1 << code;
  endfunction

endpackage

// File: rtl/sdr_burst_ctr.sv
module sdr_burst_ctr
  import sdr_dp_pkg::*;
#(
  parameter int BL_CODE_W = 2,
  localparam int CNT_W    = (1 << BL_CODE_W) - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_cmd,
  input  logic                 rd_cmd,
  input  logic [BL_CODE_W-1:0] bl_code,
  output logic                 beat_wr,
  output logic                 beat_rd
);

  logic [CNT_W-1:0] remain_q, remain_d;
  burst_dir_e       dir_q, dir_d;
  logic             start;
  burst_dir_e       start_dir;
  burst_dir_e       cur_dir;
  logic             beat;

  always_comb begin
    start     = wr_cmd | rd_cmd;
    start_dir = wr_cmd ? DIR_WR : DIR_RD;   // write wins on a tie
    remain_d  = remain_q;
    dir_d     = dir_q;
    if (start) begin
      remain_d = CNT_W'(beats_of(32'(bl_code)) - 32'd1);
      dir_d    = start_dir;
    end else if (remain_q != '0) begin
      remain_d = remain_q - CNT_W'(1);
    end
    beat    = start | (remain_q != '0);
    cur_dir = start ? start_dir : dir_q;
    beat_wr = beat & (cur_dir == DIR_WR);
    beat_rd = beat & (cur_dir == DIR_RD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      dir_q    <= DIR_RD;
    end else begin
      remain_q <= remain_d;
      dir_q    <= dir_d;
    end
  end

endmodule

// File: rtl/sdr_wr_launch.sv
module sdr_wr_launch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_wr,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_mask,
  input  logic          rd_mask,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  output logic          dqm
);

  logic          oe_d, dqm_d;
  logic [DW-1:0] dout_d;

  always_comb begin
    oe_d   = beat_wr;
    dqm_d  = beat_wr ? wr_mask : rd_mask;
    dout_d = dq_out;
    if (beat_wr) begin
      dout_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe  <= 1'b0;
      dqm    <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe  <= oe_d;
      dqm    <= dqm_d;
      dq_out <= dout_d;
    end
  end

endmodule

// File: rtl/sdr_rd_track.sv
module sdr_rd_track #(
  parameter int DW         = 8,
  parameter int CL_MIN     = 2,
  parameter int MASK_LAT   = 2,
  localparam int DEPTH     = CL_MIN + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_rd,
  input  logic             dqm_pad,
  input  logic             cas_lat3,
  input  logic [DW-1:0]    dq_in,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic [DEPTH-1:0] rd_pipe
);

  logic                beat_pad_q;
  logic [MASK_LAT-1:0] msk_pipe;
  logic                beat_tap, mask_tap, valid_d;
  logic [DW-1:0]       data_d;

  // stage aligned with the command pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_pad_q <= 1'b0;
    else        beat_pad_q <= beat_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pipe[0]  <= 1'b0;
      msk_pipe[0] <= 1'b0;
    end else begin
      rd_pipe[0]  <= beat_pad_q;
      msk_pipe[0] <= dqm_pad;
    end
  end

  for (genvar j = 1; j < DEPTH; j++) begin : g_beat_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_pipe[j] <= 1'b0;
      else        rd_pipe[j] <= rd_pipe[j-1];
    end
  end

  for (genvar j = 1; j < MASK_LAT; j++) begin : g_mask_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) msk_pipe[j] <= 1'b0;
      else        msk_pipe[j] <= msk_pipe[j-1];
    end
  end

  always_comb begin
    beat_tap = cas_lat3 ? rd_pipe[CL_MIN] : rd_pipe[CL_MIN-1];
    mask_tap = msk_pipe[MASK_LAT-1];
    valid_d  = beat_tap & ~mask_tap;
    data_d   = rd_data;
    if (valid_d) begin
      data_d = dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= valid_d;
      rd_data  <= data_d;
    end
  end

endmodule

// File: rtl/sdr_dpath.sv
module sdr_dpath #(
  parameter int DW        = 8,
  parameter int BL_CODE_W = 2,
  parameter int CL_MIN    = 2,
  parameter int MASK_LAT  = 2,
  localparam int DEPTH    = CL_MIN + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cas_lat3,
  input  logic [BL_CODE_W-1:0] bl_code,
  input  logic                 wr_cmd,
  input  logic                 rd_cmd,
  input  logic [DW-1:0]        wr_data,
  input  logic                 wr_mask,
  input  logic                 rd_mask,
  input  logic [DW-1:0]        dq_in,
  output logic                 dq_oe,
  output logic [DW-1:0]        dq_out,
  output logic                 dqm,
  output logic [DW-1:0]        rd_data,
  output logic                 rd_valid
);

  logic             beat_wr, beat_rd;
  logic [DEPTH-1:0] rd_pipe;

  sdr_burst_ctr #(
    .BL_CODE_W (BL_CODE_W)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_cmd  (wr_cmd),
    .rd_cmd  (rd_cmd),
    .bl_code (bl_code),
    .beat_wr (beat_wr),
    .beat_rd (beat_rd)
  );

  sdr_wr_launch #(
    .DW (DW)
  ) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat_wr (beat_wr),
    .wr_data (wr_data),
    .wr_mask (wr_mask),
    .rd_mask (rd_mask),
    .dq_oe   (dq_oe),
    .dq_out  (dq_out),
    .dqm     (dqm)
  );

  sdr_rd_track #(
    .DW       (DW),
    .CL_MIN   (CL_MIN),
    .MASK_LAT (MASK_LAT)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_rd  (beat_rd),
    .dqm_pad  (dqm),
    .cas_lat3 (cas_lat3),
    .dq_in    (dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_pipe  (rd_pipe)
  );

endmodule

// File: rtl/sdr_dpath_chk.sv
module sdr_dpath_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_cmd,
  input logic          rd_cmd,
  input logic [DW-1:0] wr_data,
  input logic          wr_mask,
  input logic          dq_oe,
  input logic [DW-1:0] dq_out,
  input logic          dqm,
  input logic          rd_valid
);

  AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> (dq_oe && dq_out == $past(wr_data)));                  // R3

  AST_WR_MASK_SAME_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> (dqm == $past(wr_mask)));                               // R4

  AST_RD_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && !wr_cmd) |=> !dq_oe);                                   // R7

  AST_MASKED_BEAT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$past(dqm, 3));                                      // R6

  AST_WRITE_WINS_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && rd_cmd) |=> dq_oe);                                     // R9

endmodule

bind sdr_dpath sdr_dpath_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_cmd   (wr_cmd),
  .rd_cmd   (rd_cmd),
  .wr_data  (wr_data),
  .wr_mask  (wr_mask),
  .dq_oe    (dq_oe),
  .dq_out   (dq_out),
  .dqm      (dqm),
  .rd_valid (rd_valid)
);

// File: tb/test_sdr_dpath.sv
`timescale 1ns/1ps
module test_sdr_dpath;

  logic       clk;
  logic       rst_n;
  logic       cas_lat3;
  logic [1:0] bl_code;
  logic       wr_cmd, rd_cmd;
  logic [7:0] wr_data;
  logic       wr_mask, rd_mask;
  logic [7:0] dq_in;
  logic       dq_oe;
  logic [7:0] dq_out;
  logic       dqm;
  logic [7:0] rd_data;
  logic       rd_valid;

  int n_chk  = 0;
  int n_fail = 0;
  int ecnt   = 0;
  bit done   = 0;

  sdr_dpath i_sdr_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .cas_lat3 (cas_lat3),
    .bl_code  (bl_code),
    .wr_cmd   (wr_cmd),
    .rd_cmd   (rd_cmd),
    .wr_data  (wr_data),
    .wr_mask  (wr_mask),
    .rd_mask  (rd_mask),
    .dq_in    (dq_in),
    .dq_oe    (dq_oe),
    .dq_out   (dq_out),
    .dqm      (dqm),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input int c);
    return 8'((c * 29 + 11) & 255);
  endfunction

  always @(posedge clk) ecnt <= ecnt + 1;
  always @(negedge clk) dq_in = pat(ecnt);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    wr_cmd = 0; rd_cmd = 0; wr_data = 8'h00; wr_mask = 0; rd_mask = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; cas_lat3 = 0; bl_code = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", dq_oe, 0);
    chk("R1 dqm in reset", dqm, 0);
    chk("R1 valid in reset", rd_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 dq_out after reset", dq_out, 0);
    chk("R1 rd_data after reset", rd_data, 0);
    chk("R1 valid after reset", rd_valid, 0);
  endtask

  // write burst; optional read command at iteration rd_at that cuts it short
  task automatic wr_seq(input logic [1:0] blc, input logic [7:0] base,
                        input logic [7:0] mvec, input int rd_at);
    int bl = 1 << blc;
    int last = -1;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (i >= 1) begin
        int t = i - 1;
        bit exp_oe = (t < bl) && (rd_at == 0 || t < rd_at);
        chk("R3 R2 R8 write enable", dq_oe, exp_oe);
        if (exp_oe) begin
          chk("R3 write data", dq_out, 32'(8'(base + 8'(t))));
          chk("R4 write mask same beat", dqm, mvec[t]);
          last = t;
        end else begin
          chk("R10 data held", dq_out, 32'(8'(base + 8'(last))));
          chk("R10 mask idle", dqm, 0);
        end
      end
      wr_cmd  = (i == 0);
      rd_cmd  = (rd_at != 0 && i == rd_at);
      bl_code = blc;
      wr_data = 8'(base + 8'(i));
      wr_mask = (i < 8) ? mvec[i] : 1'b0;
      rd_mask = 0;
    end
    idle_inputs();
  endtask

  // read burst(s); second command at iteration s (0 = none); mvec per input cycle
  task automatic rd_seq(input logic cl3, input logic [1:0] bl1, input int s,
                        input logic [1:0] bl2, input logic [19:0] mvec);
    int cl = cl3 ? 3 : 2;
    int c0 = 0;
    int n_beats = 0;
    int exp_beats = 0;
    logic [23:0] beat_t;
    for (int t = 0; t < 24; t++) begin
      bit b1 = (t < (1 << bl1)) && (s == 0 || t < s);
      bit b2 = (s != 0) && (t >= s) && (t < s + (1 << bl2));
      beat_t[t] = b1 | b2;
    end
    for (int i = 0; i < 22; i++) begin
      @(negedge clk);
      if (i == 0) c0 = ecnt;
      if (i >= 1) begin
        int idx = i - 2 - cl;
        bit m = (i >= 4) && (i - 4 < 20) && mvec[i-4];
        bit ev = (idx >= 0) && beat_t[idx] && !m;
        chk(cl3 ? "R5 R6 R8 valid CL3" : "R5 R6 R8 valid CL2", rd_valid, ev);
        chk("R7 bus released", dq_oe, 0);
        if (ev) begin
          chk("R5 captured beat", rd_data, pat(c0 + i - 1));
          exp_beats++;
        end
        if (rd_valid) n_beats++;
      end
      cas_lat3 = cl3;
      rd_cmd   = (i == 0) || (s != 0 && i == s);
      bl_code  = (s != 0 && i >= s) ? bl2 : bl1;
      rd_mask  = (i < 20) ? mvec[i] : 1'b0;
      wr_cmd   = 0;
    end
    chk("R2 beat count", n_beats, exp_beats);
    idle_inputs();
  endtask

  // masked beat keeps previous rd_data (R6)
  task automatic t_mask_hold();
    logic [7:0] held;
    rd_seq(1'b0, 2'd1, 0, 2'd0, 20'b0);
    held = rd_data;
    // CL2, one beat at input cycle 0, masked by request at cycle 0
    rd_seq(1'b0, 2'd0, 0, 2'd0, 20'b1);
    chk("R6 masked beat leaves rd_data", rd_data, held);
  endtask

  task automatic t_tie();
    int v = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i == 1 || i == 2) chk("R9 write taken on tie", dq_oe, 1);
      if (i == 3) chk("R9 burst length on tie", dq_oe, 0);
      if (rd_valid) v++;
      wr_cmd  = (i == 0);
      rd_cmd  = (i == 0);
      bl_code = 2'd1;
      wr_data = 8'h5A + 8'(i);
      wr_mask = 0;
    end
    chk("R9 read dropped", v, 0);
    idle_inputs();
  endtask

  initial begin
    t_reset();
    wr_seq(2'd0, 8'h10, 8'b0000_0001, 0);
    wr_seq(2'd2, 8'h40, 8'b0000_0101, 0);
    wr_seq(2'd3, 8'hA0, 8'b1001_0010, 0);
    wr_seq(2'd3, 8'h70, 8'b0000_0000, 3);       // R8 write cut by read
    repeat (6) @(negedge clk);
    rd_seq(1'b0, 2'd2, 0, 2'd0, 20'b0);
    rd_seq(1'b1, 2'd2, 0, 2'd0, 20'b0);
    rd_seq(1'b0, 2'd3, 0, 2'd0, 20'b0000_0000_0000_0010_0100);
    rd_seq(1'b1, 2'd3, 0, 2'd0, 20'b0000_0000_0000_1001_0000);
    rd_seq(1'b0, 2'd3, 3, 2'd1, 20'b0000_0000_0000_0010_0010);  // R8
    rd_seq(1'b1, 2'd3, 4, 2'd2, 20'b0000_0000_0001_0000_1000);  // R8
    t_mask_hold();
    t_tie();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule